// File: doc/BRIEF.md
# Descriptor chain DMA channel engine

This block is one transfer channel that works through a linked list of buffer descriptors kept in a small on-chip descriptor store. Software fills the store through a word-wide configuration port, turns the channel on, and writes the address of the first descriptor into the head register. The engine then reads each descriptor and issues one streaming beat per buffer byte, carrying that byte's address. When a buffer is finished, the engine writes the descriptor's mode word back with the ownership flag cleared and the moved length filled in, and then follows the next pointer.

When the engine reaches a null next pointer, it flags the descriptor as end of queue and goes idle. Software can then append descriptors and restart the channel by writing the head register again. A teardown command ends the walk once the descriptor in flight is finished. The engine flags that descriptor and loads a fixed marker value into the completion register. The marker stays pending until software writes the same value back. Each finished descriptor gives a one-cycle pulse for the interrupt logic.

Top module: `dmac_chain_engine`

## Requirements
- R1: The configuration word address selects the descriptor store when its top bit is 0 and a register when it is 1. Slot s, word w sits at store word 4*s+w, with w=0 next pointer, w=1 buffer address, w=2 length (low 11 bits used) and w=3 mode word. Descriptor s has byte address 0x1000+16*s. The registers are 0 enable (bit 0), 1 head, 2 completion, 3 teardown command and 4 status (bit 0 host error, bit 1 busy, bit 2 teardown pending). After reset every register and store word reads zero.
- R2: Once a descriptor is started, the engine gives exactly one accepted beat per byte of its length. Beat addresses run from the buffer address upward by one. The first beat carries `st_first` and the last beat carries `st_last`. While `st_ready` is low, the address holds.
- R3: Closing a descriptor rewrites its mode word. Bit 29 (owner) is cleared and bits 10:0 take the number of bytes moved. Bits 31, 30 and 26 keep their values.
- R4: A nonzero next pointer makes the engine continue with that descriptor. A zero next pointer sets bit 28 (end of queue) and leaves the channel idle.
- R5: Writing zero to the head register starts nothing.
- R6: While enable is 0, a head write is held and nothing runs until enable is set. Clearing enable during a transfer freezes the stream with no beats and `st_valid` low, and the transfer resumes when enable is set again.
- R7: After each normal close, the completion register reads the address of the descriptor just closed.
- R8: A teardown command during a walk stops the channel after the current descriptor. That descriptor gets bit 27 (teardown complete) and bit 28. Later descriptors stay untouched. The completion register reads 0xFFFFFFFC and status bit 2 is set.
- R9: While teardown is pending, head writes are ignored. Writing any value other than 0xFFFFFFFC to the completion register leaves it pending. Writing 0xFFFFFFFC clears it.
- R10: If a fetched descriptor has bit 29 clear, the engine moves no data, leaves the descriptor unchanged, sets host error (status bit 0 and `host_err`) and halts. The next nonzero head write clears the error.
- R11: `done_pulse` is high for exactly one cycle for each descriptor closed.
- R12: A descriptor with length 0 gives no beats, closes with length 0 and still pulses `done_pulse`.
- R13: A teardown command while the channel is idle sets the marker value and the pending flag without touching any descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address (store or register) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream beat accepted |
| st_addr | output | 32 | Byte address of the current beat |
| st_first | output | 1 | First beat of a buffer |
| st_last | output | 1 | Last beat of a buffer |
| done_pulse | output | 1 | One-cycle pulse per closed descriptor |
| host_err | output | 1 | Sticky ownership error flag |

## Verification
The assertions assume that descriptor pointers written by software are zero or point at a slot inside the store. They also assume that software does not rewrite the mode word of a descriptor the engine is working on. The bench only writes descriptors into slots of the channel that are idle or not yet reached, and it only uses addresses of the form 0x1000+16*s with s below the slot count. It changes `st_ready` and enable only a little after the clock edge, so the freeze and back-pressure properties see stable inputs.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int unsigned LEN_W = 11;
  localparam logic [31:0] TD_MAGIC = 32'hFFFF_FFFC;
  localparam int unsigned B_SOP = 31;
  localparam int unsigned B_EOP = 30;
  localparam int unsigned B_OWN = 29;
  localparam int unsigned B_EOQ = 28;
  localparam int unsigned B_TDC = 27;
  localparam int unsigned B_CRC = 26;

  typedef struct packed {
    logic [31:0]      nxt;
    logic [31:0]      bufa;
    logic [LEN_W-1:0] blen;
    logic [31:0]      mode;
  } desc_t;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_MOVE, W_CLOSE} walk_st_e;

  typedef enum logic [2:0] {
    RG_EN = 3'd0, RG_HEAD = 3'd1, RG_CP = 3'd2, RG_TDOWN = 3'd3, RG_STAT = 3'd4
  } reg_sel_e;

  // slot number of a descriptor byte address
  function automatic logic [31:0] slot_of(input logic [31:0] a, input logic [31:0] base);
    return (a - base) >> 4;
  endfunction

  // mode word written back when a descriptor is closed
  function automatic logic [31:0] close_mode(input logic [31:0] m,
                                             input logic [LEN_W-1:0] moved,
                                             input logic last, input logic td);
    logic [31:0] r;
    r = m;
    r[B_OWN] = 1'b0;
    r[LEN_W-1:0] = moved;
    if (last) r[B_EOQ] = 1'b1;
    if (td)   r[B_TDC] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/dmac_desc_ram.sv
`timescale 1ns/1ps
module dmac_desc_ram
  import dmac_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned WORDS = SLOTS * 4,
  localparam int unsigned AW = $clog2(WORDS),
  localparam int unsigned IW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [IW-1:0] eng_idx,
  output desc_t         eng_desc,
  input  logic          eng_we,
  input  logic [31:0]   eng_mode
);
  logic [31:0] mem [WORDS];
  logic [31:0] len_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      if (sw_we) mem[sw_addr] <= sw_wdata;
      // engine write-back has priority on a same-word collision
      if (eng_we) mem[{eng_idx, 2'd3}] <= eng_mode;
    end
  end

  assign sw_rdata      = mem[sw_addr];
  assign len_word      = mem[{eng_idx, 2'd2}];
  assign eng_desc.nxt  = mem[{eng_idx, 2'd0}];
  assign eng_desc.bufa = mem[{eng_idx, 2'd1}];
  assign eng_desc.blen = len_word[LEN_W-1:0];
  assign eng_desc.mode = mem[{eng_idx, 2'd3}];
endmodule

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        w_busy,
  input  logic        start_ack,
  input  logic        td_fire,
  input  logic        close_ev,
  input  logic [31:0] close_addr,
  input  logic        err_ev,
  output logic        en,
  output logic [31:0] head,
  output logic        start_pend,
  output logic        td_req,
  output logic        td_pend,
  output logic [31:0] cp,
  output logic        host_err
);
  logic wr_en, wr_head, wr_cp, wr_tdown, head_take;

  assign wr_en     = wr && (sel == RG_EN);
  assign wr_head   = wr && (sel == RG_HEAD);
  assign wr_cp     = wr && (sel == RG_CP);
  assign wr_tdown  = wr && (sel == RG_TDOWN);
  assign head_take = wr_head && !w_busy && !td_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      head       <= '0;
      start_pend <= 1'b0;
      td_req     <= 1'b0;
      td_pend    <= 1'b0;
      cp         <= '0;
      host_err   <= 1'b0;
    end else begin
      if (wr_en) en <= wdata[0];
      if (start_ack) start_pend <= 1'b0;
      if (head_take) begin
        head       <= wdata;
        start_pend <= (wdata != '0);
        if (wdata != '0) host_err <= 1'b0;
      end
      if (err_ev) host_err <= 1'b1;
      if (wr_tdown && !td_pend) td_req <= 1'b1;
      if (wr_cp) begin
        cp <= wdata;
        if (wdata == TD_MAGIC) td_pend <= 1'b0;
      end
      if (close_ev && !td_fire) cp <= close_addr;
      if (td_fire) begin
        cp         <= TD_MAGIC;
        td_pend    <= 1'b1;
        td_req     <= 1'b0;
        start_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    case (sel)
      RG_EN:   rdata = {31'd0, en};
      RG_HEAD: rdata = head;
      RG_CP:   rdata = cp;
      RG_STAT: rdata = {29'd0, td_pend, w_busy, host_err};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_walker.sv
`timescale 1ns/1ps
module dmac_walker
  import dmac_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter logic [31:0] DESC_BASE = 32'h0000_1000,
  localparam int unsigned IW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [31:0]   head,
  input  logic          start_pend,
  input  logic          td_req,
  input  desc_t         desc,
  output logic [IW-1:0] idx,
  output logic          mode_we,
  output logic [31:0]   mode_wd,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [31:0]   st_addr,
  output logic          st_first,
  output logic          st_last,
  output logic          busy,
  output logic          start_ack,
  output logic          td_fire,
  output logic          close_ev,
  output logic [31:0]   close_addr,
  output logic          err_ev
);
  walk_st_e         state;
  logic [31:0]      cur;
  logic [31:0]      bufa;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt;
  logic             chain_end;
  logic             beat;

  assign idx        = IW'(slot_of(cur, DESC_BASE));
  assign busy       = (state != W_IDLE);
  assign chain_end  = (desc.nxt == '0);
  assign start_ack  = en && (state == W_IDLE) && !td_req && start_pend;
  assign td_fire    = en && td_req && ((state == W_IDLE) || (state == W_CLOSE));
  assign close_ev   = en && (state == W_CLOSE);
  assign close_addr = cur;
  assign err_ev     = en && (state == W_FETCH) && !desc.mode[B_OWN];
  assign mode_we    = close_ev;
  assign mode_wd    = close_mode(desc.mode, cnt, chain_end || td_req, td_req);
  assign st_valid   = en && (state == W_MOVE);
  assign st_addr    = bufa + 32'(cnt);
  assign st_first   = (cnt == '0);
  assign st_last    = (cnt == len - 1'b1);
  assign beat       = st_valid && st_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE;
      cur   <= '0;
      bufa  <= '0;
      len   <= '0;
      cnt   <= '0;
    end else if (en) begin
      case (state)
        W_IDLE: if (start_ack) begin
          cur   <= head;
          state <= W_FETCH;
        end
        W_FETCH: if (!desc.mode[B_OWN]) begin
          state <= W_IDLE;
        end else begin
          bufa  <= desc.bufa;
          len   <= desc.blen;
          cnt   <= '0;
          state <= (desc.blen == '0) ? W_CLOSE : W_MOVE;
        end
        W_MOVE: if (beat) begin
          cnt <= cnt + 1'b1;
          if (st_last) state <= W_CLOSE;
        end
        W_CLOSE: if (td_req || chain_end) begin
          state <= W_IDLE;
        end else begin
          cur   <= desc.nxt;
          state <= W_FETCH;
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmac_chain_engine.sv
`timescale 1ns/1ps
module dmac_chain_engine
  import dmac_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter logic [31:0] DESC_BASE = 32'h0000_1000,
  localparam int unsigned RAM_AW = $clog2(SLOTS * 4),
  localparam int unsigned CFG_AW = RAM_AW + 1,
  localparam int unsigned IW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [31:0]       st_addr,
  output logic              st_first,
  output logic              st_last,
  output logic              done_pulse,
  output logic              host_err
);
  logic          reg_space;
  logic [31:0]   ram_rdata, reg_rdata;
  logic [IW-1:0] idx;
  desc_t         desc;
  logic          mode_we;
  logic [31:0]   mode_wd;
  logic          en_q, start_pend, td_req, td_pend;
  logic [31:0]   head, cp, close_addr;
  logic          busy, start_ack, td_fire, close_ev, err_ev;

  assign reg_space  = cfg_addr[CFG_AW-1];
  assign cfg_rdata  = reg_space ? reg_rdata : ram_rdata;
  assign done_pulse = close_ev;

  dmac_desc_ram #(.SLOTS(SLOTS)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .sw_we(cfg_we && !reg_space), .sw_addr(cfg_addr[RAM_AW-1:0]),
    .sw_wdata(cfg_wdata), .sw_rdata(ram_rdata),
    .eng_idx(idx), .eng_desc(desc), .eng_we(mode_we), .eng_mode(mode_wd)
  );

  dmac_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(cfg_we && reg_space), .sel(cfg_addr[2:0]), .wdata(cfg_wdata), .rdata(reg_rdata),
    .w_busy(busy), .start_ack(start_ack), .td_fire(td_fire),
    .close_ev(close_ev), .close_addr(close_addr), .err_ev(err_ev),
    .en(en_q), .head(head), .start_pend(start_pend), .td_req(td_req),
    .td_pend(td_pend), .cp(cp), .host_err(host_err)
  );

  dmac_walker #(.SLOTS(SLOTS), .DESC_BASE(DESC_BASE)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .en(en_q), .head(head), .start_pend(start_pend), .td_req(td_req),
    .desc(desc), .idx(idx), .mode_we(mode_we), .mode_wd(mode_wd),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_first(st_first), .st_last(st_last), .busy(busy),
    .start_ack(start_ack), .td_fire(td_fire), .close_ev(close_ev),
    .close_addr(close_addr), .err_ev(err_ev)
  );
endmodule

// File: rtl/dmac_chain_checker.sv
`timescale 1ns/1ps
module dmac_chain_checker
  import dmac_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        st_valid,
  input logic        st_ready,
  input logic [31:0] st_addr,
  input logic        st_last,
  input logic        done_pulse,
  input logic [31:0] close_addr,
  input logic [31:0] cp,
  input logic        td_req,
  input logic        td_pend,
  input logic        busy,
  input logic        host_err
);
  assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !st_last) |=> (st_addr == $past(st_addr) + 32'd1));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> $stable(st_addr));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(st_addr));

  assert_cp_tracks_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !td_req) |=> (cp == $past(close_addr)));

  assert_td_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && td_req) |=> (td_pend && !busy && cp == TD_MAGIC));

  assert_pend_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    td_pend |-> !busy);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> !st_valid);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

bind dmac_chain_engine dmac_chain_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .st_valid(st_valid), .st_ready(st_ready),
  .st_addr(st_addr), .st_last(st_last), .done_pulse(done_pulse),
  .close_addr(close_addr), .cp(cp), .td_req(td_req), .td_pend(td_pend),
  .busy(busy), .host_err(host_err)
);

// File: tb/dmac_chain_engine_test.sv
`timescale 1ns/1ps
module dmac_chain_engine_test;
  localparam logic [5:0] A_EN = 6'd32, A_HEAD = 6'd33, A_CP = 6'd34, A_TD = 6'd35, A_ST = 6'd36;
  localparam logic [31:0] MAGIC = 32'hFFFF_FFFC;
  localparam logic [31:0] OWN = 32'h2000_0000, SOPEOP = 32'hC000_0000, CRC = 32'h0400_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic st_valid, st_ready = 1'b1, st_first, st_last, done_pulse, host_err;
  logic [31:0] st_addr;

  int checks = 0, errs = 0, nb = 0, ndone = 0;
  bit bp_mode = 1'b0, finished = 1'b0;
  logic [31:0] log_addr [1024];
  bit log_first [1024], log_last [1024];

  dmac_chain_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_first(st_first), .st_last(st_last), .done_pulse(done_pulse), .host_err(host_err)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      for (int k = 0; k < 1000000; k++) begin
        @(posedge clk); #1;
        st_ready = bp_mode ? ((k % 3) != 0) : 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (st_valid && st_ready && nb < 1024) begin
        log_addr[nb] = st_addr; log_first[nb] = st_first; log_last[nb] = st_last;
        nb = nb + 1;
      end
      if (done_pulse) ndone = ndone + 1;
    end
  end

  function automatic logic [31:0] daddr(input int s);
    return 32'h1000 + 32'(s) * 32'd16;
  endfunction

  function automatic logic [31:0] closed(input logic [31:0] m, input int moved, input bit eoq, input bit td);
    return (m & ~OWN & ~32'h7FF) | 32'(moved) | (eoq ? 32'h1000_0000 : 32'd0) | (td ? 32'h0800_0000 : 32'd0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic put_desc(input int s, input logic [31:0] nxt, input logic [31:0] ba,
                          input int len, input logic [31:0] mode);
    wr(6'(s * 4 + 0), nxt);
    wr(6'(s * 4 + 1), ba);
    wr(6'(s * 4 + 2), 32'(len));
    wr(6'(s * 4 + 3), mode);
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 500; i++) begin
      rd(A_ST, st);
      if (st[1] == 1'b0) break;
    end
  endtask

  task automatic check_beats(input string tag, input int first, input int cnt, input logic [31:0] base);
    int bad;
    bad = 0;
    for (int i = 0; i < cnt; i++) begin
      if (log_addr[first + i] !== base + 32'(i)) bad++;
      if (log_first[first + i] != (i == 0)) bad++;
      if (log_last[first + i] != (i == cnt - 1)) bad++;
    end
    chk(tag, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, m;
    int nb0, d0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_ST, v);   chk("R1 status after reset", v, 32'd0);
    rd(A_CP, v);   chk("R1 cp after reset", v, 32'd0);
    rd(A_HEAD, v); chk("R1 head after reset", v, 32'd0);
    rd(6'd7, v);   chk("R1 store word after reset", v, 32'd0);
    chk("R1 stream idle after reset", {31'd0, st_valid}, 32'd0);
    wr(A_EN, 32'd1);
    rd(A_EN, v);   chk("R1 enable readback", v, 32'd1);

    // R2 R3 R4 R7 R11 single descriptor
    m = SOPEOP | OWN | CRC | 32'd5;
    put_desc(0, 32'd0, 32'h2000, 5, m);
    nb0 = nb; d0 = ndone;
    wr(A_HEAD, daddr(0));
    wait_idle();
    chk("R2 beat count", 32'(nb - nb0), 32'd5);
    check_beats("R2 beat addresses and flags", nb0, 5, 32'h2000);
    rd(6'd3, v); chk("R3 R4 closed mode word", v, closed(m, 5, 1, 0));
    rd(A_CP, v); chk("R7 cp after close", v, daddr(0));
    chk("R11 done pulses", 32'(ndone - d0), 32'd1);

    // R2 R3 R12 sweep over lengths with and without back-pressure
    for (int L = 0; L <= 12; L++) begin
      int s;
      s = L % 8;
      bp_mode = L[0];
      m = SOPEOP | OWN | 32'(L);
      put_desc(s, 32'd0, 32'h4000 + 32'(L) * 32'h40, L, m);
      nb0 = nb; d0 = ndone;
      wr(A_HEAD, daddr(s));
      wait_idle();
      chk($sformatf("R2 R12 sweep len %0d beats", L), 32'(nb - nb0), 32'(L));
      check_beats($sformatf("R2 sweep len %0d addresses", L), nb0, L, 32'h4000 + 32'(L) * 32'h40);
      rd(6'(s * 4 + 3), v); chk($sformatf("R3 R12 sweep len %0d mode", L), v, closed(m, L, 1, 0));
      chk($sformatf("R11 sweep len %0d done", L), 32'(ndone - d0), 32'd1);
    end

    // R4 R12 chain of three, middle one empty, with back-pressure
    bp_mode = 1'b1;
    put_desc(1, daddr(2), 32'h3000, 3, SOPEOP | OWN | 32'd3);
    put_desc(2, daddr(3), 32'h3100, 0, SOPEOP | OWN);
    put_desc(3, 32'd0, 32'h3200, 7, SOPEOP | OWN | 32'd7);
    nb0 = nb; d0 = ndone;
    wr(A_HEAD, daddr(1));
    wait_idle();
    bp_mode = 1'b0;
    chk("R4 chain total beats", 32'(nb - nb0), 32'd10);
    check_beats("R4 chain first buffer", nb0, 3, 32'h3000);
    check_beats("R4 chain third buffer", nb0 + 3, 7, 32'h3200);
    rd(6'd7, v);  chk("R4 chain first mode no eoq", v, closed(SOPEOP | OWN | 32'd3, 3, 0, 0));
    rd(6'd11, v); chk("R12 chain empty mode", v, closed(SOPEOP | OWN, 0, 0, 0));
    rd(6'd15, v); chk("R4 chain last mode eoq", v, closed(SOPEOP | OWN | 32'd7, 7, 1, 0));
    rd(A_CP, v);  chk("R7 cp after chain", v, daddr(3));
    chk("R11 chain done pulses", 32'(ndone - d0), 32'd3);

    // R5 head zero
    nb0 = nb;
    wr(A_HEAD, 32'd0);
    repeat (10) @(posedge clk);
    rd(A_ST, v); chk("R5 busy after zero head", {31'd0, v[1]}, 32'd0);
    chk("R5 no beats after zero head", 32'(nb - nb0), 32'd0);

    // R6 enable gating of start
    wr(A_EN, 32'd0);
    put_desc(4, 32'd0, 32'h5000, 4, SOPEOP | OWN | 32'd4);
    nb0 = nb;
    wr(A_HEAD, daddr(4));
    repeat (10) @(posedge clk);
    chk("R6 no beats while disabled", 32'(nb - nb0), 32'd0);
    rd(A_HEAD, v); chk("R6 head latched while disabled", v, daddr(4));
    wr(A_EN, 32'd1);
    wait_idle();
    chk("R6 beats after enable", 32'(nb - nb0), 32'd4);

    // R6 freeze mid-transfer
    m = SOPEOP | OWN | 32'd20;
    put_desc(5, 32'd0, 32'h6000, 20, m);
    nb0 = nb;
    wr(A_HEAD, daddr(5));
    repeat (6) @(posedge clk);
    wr(A_EN, 32'd0);
    repeat (2) @(posedge clk);
    d0 = nb;
    repeat (10) @(posedge clk);
    chk("R6 frozen beat count", 32'(nb - d0), 32'd0);
    @(negedge clk);
    chk("R6 valid low while frozen", {31'd0, st_valid}, 32'd0);
    chk("R6 transfer was mid-way", {31'd0, ((d0 - nb0) > 0 && (d0 - nb0) < 20) ? 1'b1 : 1'b0}, 32'd1);
    wr(A_EN, 32'd1);
    wait_idle();
    chk("R6 resumed total beats", 32'(nb - nb0), 32'd20);
    check_beats("R6 resumed addresses", nb0, 20, 32'h6000);
    rd(6'd23, v); chk("R6 resumed mode", v, closed(m, 20, 1, 0));

    // R10 ownership error
    m = SOPEOP | 32'd3;
    put_desc(6, 32'd0, 32'h7000, 3, m);
    nb0 = nb; d0 = ndone;
    wr(A_HEAD, daddr(6));
    wait_idle();
    rd(A_ST, v); chk("R10 status host error", {31'd0, v[0]}, 32'd1);
    chk("R10 host_err port", {31'd0, host_err}, 32'd1);
    rd(6'd27, v); chk("R10 mode unchanged", v, m);
    chk("R10 no beats", 32'(nb - nb0), 32'd0);
    chk("R10 no done pulse", 32'(ndone - d0), 32'd0);
    put_desc(0, 32'd0, 32'h2000, 2, SOPEOP | OWN | 32'd2);
    wr(A_HEAD, daddr(0));
    wait_idle();
    rd(A_ST, v); chk("R10 error cleared by new head", {31'd0, v[0]}, 32'd0);

    // R8 teardown during a walk
    m = SOPEOP | OWN | 32'd30;
    put_desc(1, daddr(2), 32'h8000, 30, m);
    put_desc(2, 32'd0, 32'h9000, 30, m);
    nb0 = nb; d0 = ndone;
    wr(A_HEAD, daddr(1));
    repeat (4) @(posedge clk);
    wr(A_TD, 32'd1);
    wait_idle();
    chk("R8 only current buffer moved", 32'(nb - nb0), 32'd30);
    rd(6'd7, v);  chk("R8 torn-down descriptor flags", v, closed(m, 30, 1, 1));
    rd(6'd11, v); chk("R8 later descriptor untouched", v, m);
    rd(A_CP, v);  chk("R8 cp marker", v, MAGIC);
    rd(A_ST, v);  chk("R8 teardown pending", {31'd0, v[2]}, 32'd1);
    chk("R11 teardown done pulses", 32'(ndone - d0), 32'd1);

    // R9 pending teardown blocks head, cleared only by marker
    nb0 = nb;
    wr(A_HEAD, daddr(2));
    repeat (10) @(posedge clk);
    chk("R9 head ignored while pending", 32'(nb - nb0), 32'd0);
    rd(A_HEAD, v); chk("R9 head register unchanged", v, daddr(1));
    wr(A_CP, 32'h0000_1234);
    rd(A_ST, v); chk("R9 other value keeps pending", {31'd0, v[2]}, 32'd1);
    wr(A_CP, MAGIC);
    rd(A_ST, v); chk("R9 marker clears pending", {31'd0, v[2]}, 32'd0);

    // R13 teardown while idle
    d0 = ndone;
    wr(A_TD, 32'd1);
    repeat (3) @(posedge clk);
    rd(A_CP, v); chk("R13 idle teardown marker", v, MAGIC);
    rd(A_ST, v); chk("R13 idle teardown pending", v, 32'd4);
    rd(6'd11, v); chk("R13 descriptor untouched", v, m);
    chk("R13 no done pulse", 32'(ndone - d0), 32'd0);
    wr(A_CP, MAGIC);
    rd(A_ST, v); chk("R9 idle marker cleared", v, 32'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule